// File: doc/BRIEF.md
# Masked Instruction Fetch Breakpoint Comparator

This block watches the instruction fetch stream and raises a break request when a fetch falls inside one programmable breakpoint window. The window is a base address plus a mask: every address bit whose mask bit is set is ignored. The lowest address bit does not hold a byte address. It holds the ISA mode of the fetch, so a breakpoint can be limited to compressed 16-bit code or to standard 32-bit code. A breakpoint can also be tied to one address space identifier (ASID).

Software programs three registers through a simple write port: the base address, the mask, and a control word with an enable, an ASID-use flag and an ASID value. Each fetch arrives with a valid strobe, its address, its ISA-mode bit, the current ASID, and a flag that marks the trailing halfword of an extended 16-bit instruction. A trailing halfword is not a whole instruction, so it never causes a break. When a fetch matches, `brk_req` is high for one cycle, one clock after the fetch is presented.

Top module: `ibrk_top`

## Requirements
- R1: After synchronous reset, `brk_req` is 0 and all three registers are 0, so the breakpoint is disabled.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the register chosen by `cfg_sel`: 0 is the base address, 1 is the mask and 2 is the control word. In the control word, bit 0 is the enable, bit 1 is ASID-use and bits 15:8 are the ASID. A write with select 3 changes nothing. A written value applies to every fetch presented in the cycles after the write edge.
- R3: Each address bit whose mask bit is 1 is a don't-care, and every other bit must equal the base address. For example, base 0x10 with mask 0xC matches 0x10, 0x14, 0x18 and 0x1C, and does not match 0x0C or 0x20.
- R4: In the comparison, bit 0 of the base address is checked against `fetch_isa16` in place of `fetch_addr[0]`, with 1 meaning compressed mode. For example, base 0x31 with mask 0x6 matches compressed fetches at 0x30 through 0x36 and does not match 32-bit fetches at those addresses.
- R5: No break request is raised while the enable bit is 0.
- R6: When ASID-use is 1, `fetch_asid` must also equal the programmed ASID. When ASID-use is 0, `fetch_asid` has no effect.
- R7: A fetch with `fetch_ext_tail`=1 never raises a break, even if its address matches. The halfword that follows it matches normally.
- R8: `brk_req` is registered. It is high for exactly the one cycle after each matching fetch with `fetch_valid`=1, and it is low after any cycle with `fetch_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base address, 1 mask, 2 control, 3 unused |
| cfg_wdata | input | 32 | Register write data |
| fetch_valid | input | 1 | A fetch is present this cycle |
| fetch_addr | input | 32 | Fetch address; bit 0 is not compared |
| fetch_isa16 | input | 1 | Fetch is in compressed 16-bit mode |
| fetch_asid | input | 8 | ASID of the current process |
| fetch_ext_tail | input | 1 | Fetch is the trailing half of an extended 16-bit instruction |
| brk_req | output | 1 | One-cycle break request |

## Verification
The main stimulus is a table of fetches run against a window with a 2-bit mask and an ASID requirement. It tries every address inside the window, addresses just below and just above it, a wrong ASID, a wrong ISA-mode bit and a trailing halfword. Each of these shows which of the four qualifying conditions blocks the break. A second window tied to the ISA-mode bit runs an extended-instruction sequence. It shows that the trailing halfword is skipped while the next halfword still breaks, and that the same addresses in 32-bit mode do not match. Directed checks cover the reset state, disabling and then re-enabling the breakpoint with a fetch in the cycle right after the write, an ignored write with select 3, and a pulse that falls when fetches stop.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
  localparam int CFG_SEL_W = 2;

  typedef enum logic [CFG_SEL_W-1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  // Control word field positions
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_USE_BIT  = 1;
  localparam int CTRL_ASID_LSB = 8;
endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
  import ibrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_SEL_W-1:0] cfg_sel,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  output logic [ADDR_W-1:0]    base_q,
  output logic [ADDR_W-1:0]    mask_q,
  output logic                 en_q,
  output logic                 use_q,
  output logic [ASID_W-1:0]    asid_q
);
  localparam int ASID_MSB = CTRL_ASID_LSB + ASID_W - 1;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
      use_q  <= 1'b0;
      asid_q <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_BASE: base_q <= cfg_wdata;
        SEL_MASK: mask_q <= cfg_wdata;
        SEL_CTRL: begin
          en_q   <= cfg_wdata[CTRL_EN_BIT];
          use_q  <= cfg_wdata[CTRL_USE_BIT];
          asid_q <= cfg_wdata[ASID_MSB:CTRL_ASID_LSB];
        end
        default: ;
      endcase
    end
  end

  // R2: a mask write lands in the register at the next edge
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_MASK) |=> (mask_q == $past(cfg_wdata)));

  // R2: select 3 leaves the base register untouched
  assert_sel_none_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_NONE) |=> $stable(base_q));
endmodule

// File: rtl/ibrk_addr_cmp.sv
module ibrk_addr_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isa16,
  output logic              hit
);
  logic [ADDR_W-1:0] bit_ok;

  // Bit 0 carries the ISA mode; the other bits carry the address.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i == 0) begin : g_mode
      assign bit_ok[i] = mask[i] | (isa16 == base[i]);
    end else begin : g_addr
      assign bit_ok[i] = mask[i] | (addr[i] == base[i]);
    end
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/ibrk_ctx_cmp.sv
module ibrk_ctx_cmp #(
  parameter int ASID_W = 8
) (
  input  logic              use_asid,
  input  logic [ASID_W-1:0] bp_asid,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              ok
);
  assign ok = !use_asid || (bp_asid == cur_asid);
endmodule

// File: rtl/ibrk_top.sv
module ibrk_top
  import ibrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_SEL_W-1:0] cfg_sel,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  input  logic                 fetch_valid,
  input  logic [ADDR_W-1:0]    fetch_addr,
  input  logic                 fetch_isa16,
  input  logic [ASID_W-1:0]    fetch_asid,
  input  logic                 fetch_ext_tail,
  output logic                 brk_req
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] mask_q;
  logic              en_q;
  logic              use_q;
  logic [ASID_W-1:0] asid_q;
  logic              addr_hit;
  logic              ctx_ok;
  logic              brk_q;

  ibrk_regs #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .base_q    (base_q),
    .mask_q    (mask_q),
    .en_q      (en_q),
    .use_q     (use_q),
    .asid_q    (asid_q)
  );

  ibrk_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
    .base  (base_q),
    .mask  (mask_q),
    .addr  (fetch_addr),
    .isa16 (fetch_isa16),
    .hit   (addr_hit)
  );

  ibrk_ctx_cmp #(.ASID_W(ASID_W)) u_ctx (
    .use_asid (use_q),
    .bp_asid  (asid_q),
    .cur_asid (fetch_asid),
    .ok       (ctx_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= fetch_valid & ~fetch_ext_tail & en_q & addr_hit & ctx_ok;
  end

  assign brk_req = brk_q;

  // R8: no fetch, no request in the following cycle
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !brk_req);

  // R7: trailing halfword never breaks
  assert_tail_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_ext_tail) |=> !brk_req);

  // R5: disabled breakpoint never fires
  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !brk_req);

  // R6: ASID mismatch blocks the request when ASID-use is set
  assert_asid_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (use_q && fetch_asid != asid_q) |=> !brk_req);

  // R3: address outside the window blocks the request
  assert_outside_R3: assert property (@(posedge clk) disable iff (rst)
    !addr_hit |=> !brk_req);

  // R4: unmasked ISA-mode mismatch blocks the request
  assert_mode_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (!mask_q[0] && fetch_isa16 != base_q[0]) |=> !brk_req);
endmodule

// File: tb/tb_ibrk_top.sv
module tb_ibrk_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_isa16 = 1'b0;
  logic [7:0]  fetch_asid = '0;
  logic        fetch_ext_tail = 1'b0;
  logic        brk_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ibrk_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_isa16(fetch_isa16), .fetch_asid(fetch_asid),
    .fetch_ext_tail(fetch_ext_tail), .brk_req(brk_req)
  );

  // {addr, isa16, asid, tail, expected}; window base 0x10 mask 0xC, ASID 5 required
  localparam int NV = 12;
  localparam logic [42:0] TBL [0:NV-1] = '{
    {32'h10, 1'b0, 8'h05, 1'b0, 1'b1},  // R3 low edge
    {32'h14, 1'b0, 8'h05, 1'b0, 1'b1},  // R3
    {32'h18, 1'b0, 8'h05, 1'b0, 1'b1},  // R3
    {32'h1C, 1'b0, 8'h05, 1'b0, 1'b1},  // R3 high edge
    {32'h20, 1'b0, 8'h05, 1'b0, 1'b0},  // R3 above
    {32'h0C, 1'b0, 8'h05, 1'b0, 1'b0},  // R3 below
    {32'h11, 1'b0, 8'h05, 1'b0, 1'b1},  // R4 addr bit0 not compared
    {32'h10, 1'b1, 8'h05, 1'b0, 1'b0},  // R4 wrong mode
    {32'h10, 1'b0, 8'h06, 1'b0, 1'b0},  // R6 wrong ASID
    {32'h14, 1'b0, 8'h05, 1'b1, 1'b0},  // R7 tail suppressed
    {32'h18, 1'b0, 8'h05, 1'b0, 1'b1},  // R7 next halfword matches
    {32'h1010, 1'b0, 8'h05, 1'b0, 1'b0} // R3 high bit differs
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (brk_req !== exp) begin
      failures++;
      $display("FAIL %s: brk_req=%b expected=%b", tag, brk_req, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] a, input logic m, input logic [7:0] id,
                       input logic tail, input logic exp, input string tag);
    fetch_valid = 1'b1; fetch_addr = a; fetch_isa16 = m;
    fetch_asid = id; fetch_ext_tail = tail;
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic idle(input string tag);
    fetch_valid = 1'b0;
    @(negedge clk);
    check(1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1'b0, "R1 reset output");
    // R1: registers zero means disabled, even for a fetch matching base 0 mask 0
    fetch(32'h0, 1'b0, 8'h00, 1'b0, 1'b0, "R1 reset disabled");
    idle("R8 idle after fetch");

    // Window A: R2 field layout (enable bit0, use bit1, ASID bits 15:8)
    wr(2'd0, 32'h10);
    wr(2'd1, 32'hC);
    wr(2'd2, 32'h0000_0503);
    for (int i = 0; i < NV; i++) begin
      fetch(TBL[i][42:11], TBL[i][10], TBL[i][9:2], TBL[i][1], TBL[i][0],
            $sformatf("R3/R4/R6/R7 vector %0d", i));
    end
    idle("R8 pulse ends when fetches stop");

    // Window B: compressed range 0x30..0x36, ASID ignored
    wr(2'd0, 32'h31);
    wr(2'd1, 32'h6);
    wr(2'd2, 32'h0000_0001);
    fetch(32'h30, 1'b1, 8'h99, 1'b1, 1'b0, "R7 trailing half at 0x30");
    fetch(32'h32, 1'b1, 8'h99, 1'b0, 1'b1, "R7 first whole instr 0x32");
    fetch(32'h34, 1'b1, 8'h00, 1'b0, 1'b1, "R6 ASID ignored 0x34");
    fetch(32'h36, 1'b1, 8'h42, 1'b0, 1'b1, "R4 top of compressed range");
    fetch(32'h38, 1'b1, 8'h42, 1'b0, 1'b0, "R4 past range");
    fetch(32'h32, 1'b0, 8'h42, 1'b0, 1'b0, "R4 32-bit mode no match");
    idle("R8 idle");

    // R5: disable, then re-enable with a fetch right after the write
    wr(2'd2, 32'h0);
    fetch(32'h32, 1'b1, 8'h00, 1'b0, 1'b0, "R5 disabled");
    fetch_valid = 1'b0;
    wr(2'd2, 32'h1);
    fetch(32'h32, 1'b1, 8'h00, 1'b0, 1'b1, "R2 write applies next fetch");
    fetch_valid = 1'b0;

    // R2: select 3 write changes nothing
    wr(2'd3, 32'hFFFF_FFFF);
    fetch(32'h38, 1'b1, 8'h00, 1'b0, 1'b0, "R2 sel3 ignored outside");
    fetch(32'h32, 1'b1, 8'h00, 1'b0, 1'b1, "R2 sel3 ignored inside");
    idle("R8 final idle");

    // R1: reset mid-run clears config
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    fetch(32'h32, 1'b1, 8'h00, 1'b0, 1'b0, "R1 reset clears enable");
    idle("R1 idle after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule